// File: doc/BRIEF.md
# Three-phase sinusoidal PWM generator

This block drives the six gates of a three-leg voltage source inverter. It compares three sine references against one triangular carrier. The carrier is an up/down counter that sweeps from zero to its peak and back without pausing. A phase accumulator steps through a 256-sample sine table. Three read ports take the table at the accumulator phase plus offsets of zero, one third and two thirds of a turn. Each sample is scaled by an amplitude input and centred on the carrier midpoint, which gives one compare value per leg.

A compare value is updated only while the carrier sits at zero, so duty never changes within a carrier period. A leg is in the high state whenever its compare value is below the carrier. That state selects the upper or lower switch of the leg. Every change of state first blanks both switches for a fixed number of clocks. For one whole carrier period after reset, every gate stays off.

The fundamental frequency comes from the tuning word and the carrier period. The modulation depth comes from the amplitude input.

Top module: `tri_spwm_gen`

## Requirements
- R1: The carrier starts at 0 after reset and moves by one per clock. It climbs to 2^CAR_W-1, descends to 0 and repeats, so one period is 2*(2^CAR_W-1) clocks.
- R2: A leg's state is 1 when its compare value is strictly less than the carrier and 0 otherwise. State 1 selects the upper switch (gate_hi) and state 0 selects the lower switch (gate_lo). Bit 0 of each gate vector is leg A, bit 1 is leg B and bit 2 is leg C.
- R3: The sine sample at table index n (0..255) is built as follows. Let k = n mod 128 and q = k*(128-k). The magnitude is floor(2032*q/(81920-4*q)). The sample is this magnitude, negated when n >= 128.
- R4: A PH_W-bit phase accumulator is 0 after reset and adds freq_word once per carrier period. Each leg indexes the table with the top 8 bits of (accumulator + offset). The offsets are 0 for A, floor(2^PH_W/3) for B and floor(2^(PH_W+1)/3) for C. The sample for a period uses the accumulator value from before that period's addition.
- R5: A leg's compare value is 2^(CAR_W-1) + floor(sample*amp / 2^(16-CAR_W)). amp is an unsigned 8-bit value, and 255 is full scale.
- R6: With amp = 0 every leg compares at the midpoint. Each period, the upper switch then conducts for 2*(2^CAR_W-1-2^(CAR_W-1))-1-DEAD_CYC clocks.
- R7: The compare values and the accumulator change only at the clock edge where the carrier is 0. A change of freq_word or amp at any other time has no effect until that edge.
- R8: After a leg changes state, both of its gates are off for exactly DEAD_CYC clocks, starting one clock after the change. The newly selected switch turns on after that.
- R9: The upper and lower gate of a leg are never on in the same cycle.
- R10: All six gates are low during reset. They stay low until the carrier has returned to 0 once after reset, and are released at the clock edge that leaves that zero, which is edge 2*(2^CAR_W-1)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | PH_W | Phase step added once per carrier period |
| amp | input | 8 | Modulation amplitude, unsigned, 255 = full scale |
| gate_hi | output | 3 | Upper switch gates, bit 0 = leg A |
| gate_lo | output | 3 | Lower switch gates, bit 0 = leg A |

## Verification
The bench builds the block with CAR_W = 4, DEAD_CYC = 2 and PH_W = 24. With these values the carrier spans only 0..15 and a period lasts 30 clocks. All 256 table indices can therefore be swept at full amplitude, and several tuning words and amplitudes can follow, within a few thousand periods. Every compare value from 0 to 15 is reached, including the extremes where a leg barely switches. A cycle-by-cycle arithmetic model in the bench covers amplitude and frequency changes made part-way through a period, dead-time blanking around every transition, and the release of the gates after startup.

// File: rtl/tri_spwm_pkg.sv
package tri_spwm_pkg;

  localparam int SMP_W  = 8;
  localparam int AMP_W  = 8;
  localparam int TBL_AW = 8;
  localparam int TBL_N  = 1 << TBL_AW;
  localparam int NLEG   = 3;

  // Quarter-free rational approximation of one sine period, 127 = peak.
  function automatic logic signed [SMP_W-1:0] sine_sample(input logic [TBL_AW-1:0] idx);
    int k;
    int q;
    int mag;
    logic signed [SMP_W-1:0] r;
    k   = int'(idx[TBL_AW-2:0]);
    q   = k * (128 - k);
    mag = (2032 * q) / (81920 - 4 * q);
    r   = SMP_W'(mag);
    if (idx[TBL_AW-1]) r = -r;
    return r;
  endfunction

  // Signed sample times unsigned amplitude, floor-divided by 2^sh.
  function automatic int scaled_offset(input logic signed [SMP_W-1:0] s,
                                       input logic [AMP_W-1:0] a,
                                       input int sh);
    int p;
    p = int'(s) * int'(a);
    return p >>> sh;
  endfunction

endpackage

// File: rtl/tri_spwm_carrier.sv
module tri_spwm_carrier #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CAR_W-1:0] cnt,
  output logic             at_min,
  output logic             at_max
);
  localparam logic [CAR_W-1:0] TOP    = '1;
  localparam logic [CAR_W-1:0] TOP_M1 = TOP - 1'b1;
  localparam logic [CAR_W-1:0] ONE    = CAR_W'(1);

  logic up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else if (up_q) begin
      cnt <= cnt + ONE;
      if (cnt == TOP_M1) up_q <= 1'b0;
    end else begin
      cnt <= cnt - ONE;
      if (cnt == ONE) up_q <= 1'b1;
    end
  end

  assign at_min = (cnt == '0);
  assign at_max = (cnt == TOP);

endmodule

// File: rtl/tri_spwm_sine_rom.sv
module tri_spwm_sine_rom
  import tri_spwm_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic        [TBL_AW-1:0] addr [NRD],
  output logic signed [SMP_W-1:0]  data [NRD]
);
  logic signed [SMP_W-1:0] tbl [TBL_N];

  for (genvar e = 0; e < TBL_N; e++) begin : g_tbl
    assign tbl[e] = sine_sample(TBL_AW'(e));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign data[r] = tbl[addr[r]];
  end

endmodule

// File: rtl/tri_spwm_leg.sv
module tri_spwm_leg #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req,
  output logic hi,
  output logic lo
);
  localparam int DT_W = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD_CYC);

  logic            cur_q;
  logic [DT_W-1:0] tmr_q;
  logic            settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 1'b0;
      tmr_q <= '0;
    end else if (req != cur_q) begin
      cur_q <= req;
      tmr_q <= DT_LOAD;
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign settled = (tmr_q == '0);
  assign hi = en & cur_q & settled;
  assign lo = en & ~cur_q & settled;

endmodule

// File: rtl/tri_spwm_gen.sv
module tri_spwm_gen
  import tri_spwm_pkg::*;
#(
  parameter int CAR_W    = 8,
  parameter int PH_W     = 24,
  parameter int DEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   freq_word,
  input  logic [AMP_W-1:0]  amp,
  output logic [NLEG-1:0]   gate_hi,
  output logic [NLEG-1:0]   gate_lo
);
  localparam int MID      = 1 << (CAR_W - 1);
  localparam int SCALE_SH = SMP_W + AMP_W - CAR_W;

  // carrier
  logic [CAR_W-1:0] car_cnt;
  logic             car_at_min;
  logic             car_at_max;

  tri_spwm_carrier #(.CAR_W(CAR_W)) u_car (
    .clk    (clk),
    .rst    (rst),
    .cnt    (car_cnt),
    .at_min (car_at_min),
    .at_max (car_at_max)
  );

  // phase and table lookup
  logic        [PH_W-1:0]   ph_acc;
  logic        [TBL_AW-1:0] rd_addr [NLEG];
  logic signed [SMP_W-1:0]  rd_data [NLEG];

  for (genvar g = 0; g < NLEG; g++) begin : g_idx
    localparam logic [PH_W-1:0] OFS = PH_W'(((64'd1 << PH_W) * g) / 3);
    logic [PH_W-1:0] ph_sum;
    assign ph_sum     = ph_acc + OFS;
    assign rd_addr[g] = ph_sum[PH_W-1 -: TBL_AW];
  end

  tri_spwm_sine_rom #(.NRD(NLEG)) u_rom (
    .addr (rd_addr),
    .data (rd_data)
  );

  // compare values, held for a full carrier period
  logic [NLEG-1:0][CAR_W-1:0] cmp_next;
  logic [NLEG-1:0][CAR_W-1:0] cmp_q;

  always_comb begin
    for (int i = 0; i < NLEG; i++) begin
      cmp_next[i] = CAR_W'(MID + scaled_offset(rd_data[i], amp, SCALE_SH));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_acc <= '0;
      for (int i = 0; i < NLEG; i++) cmp_q[i] <= CAR_W'(MID);
    end else if (car_at_min) begin
      ph_acc <= ph_acc + freq_word;
      cmp_q  <= cmp_next;
    end
  end

  // startup hold: release after the first full carrier period
  logic seen_peak_q;
  logic gate_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_peak_q <= 1'b0;
      gate_en_q   <= 1'b0;
    end else begin
      if (car_at_max) seen_peak_q <= 1'b1;
      if (car_at_min && seen_peak_q) gate_en_q <= 1'b1;
    end
  end

  // per-leg comparison and dead time
  logic [NLEG-1:0] leg_req;

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    assign leg_req[g] = (cmp_q[g] < car_cnt);

    tri_spwm_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk (clk),
      .rst (rst),
      .en  (gate_en_q),
      .req (leg_req[g]),
      .hi  (gate_hi[g]),
      .lo  (gate_lo[g])
    );
  end

endmodule

// File: rtl/tri_spwm_gen_chk.sv
module tri_spwm_gen_chk #(
  parameter int CAR_W    = 8,
  parameter int PH_W     = 24,
  parameter int DEAD_CYC = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CAR_W-1:0]       car_cnt,
  input logic                   car_at_min,
  input logic                   car_at_max,
  input logic [PH_W-1:0]        ph_acc,
  input logic [PH_W-1:0]        freq_word,
  input logic [2:0][CAR_W-1:0]  cmp_q,
  input logic [2:0]             leg_req,
  input logic [2:0]             gate_hi,
  input logic [2:0]             gate_lo
);
  localparam int CMAX = (1 << CAR_W) - 1;
  localparam int HOLD = 2 * CMAX;

  logic [CAR_W+1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst) since_q <= '0;
    else if (int'(since_q) != HOLD + 1) since_q <= since_q + 1'b1;
  end

  // R1
  peak_turn_chk: assert property (@(posedge clk) disable iff (rst)
    car_at_max |=> (int'(car_cnt) == CMAX - 1));

  // R1
  floor_turn_chk: assert property (@(posedge clk) disable iff (rst)
    car_at_min |=> (car_cnt == CAR_W'(1)));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    car_at_min |=> (ph_acc == $past(ph_acc + freq_word)));

  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !car_at_min |=> ($stable(cmp_q) && $stable(ph_acc)));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  // R10
  startup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(since_q) <= HOLD) |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  for (genvar i = 0; i < 3; i++) begin : g_leg_chk
    // R2
    hi_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      gate_hi[i] |-> $past(leg_req[i]));

    // R2
    lo_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      gate_lo[i] |-> !$past(leg_req[i]));

    if (DEAD_CYC > 0) begin : g_dt
      // R8
      blank_after_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $changed(leg_req[i]) |=> (!gate_hi[i] && !gate_lo[i]));
    end
  end

endmodule

bind tri_spwm_gen tri_spwm_gen_chk #(
  .CAR_W    (CAR_W),
  .PH_W     (PH_W),
  .DEAD_CYC (DEAD_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .car_cnt    (car_cnt),
  .car_at_min (car_at_min),
  .car_at_max (car_at_max),
  .ph_acc     (ph_acc),
  .freq_word  (freq_word),
  .cmp_q      (cmp_q),
  .leg_req    (leg_req),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo)
);

// File: tb/tri_spwm_gen_tb.sv
`timescale 1ns/1ps
module tri_spwm_gen_tb;
  localparam int CW     = 4;
  localparam int PW     = 24;
  localparam int DT     = 2;
  localparam int MAXC   = (1 << CW) - 1;
  localparam int MIDC   = 1 << (CW - 1);
  localparam int PERIOD = 2 * MAXC;
  localparam int DIVC   = 1 << (16 - CW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] fw  = '0;
  logic [7:0]    amp = '0;
  logic [2:0]    ghi;
  logic [2:0]    glo;

  always #10 clk = ~clk;

  tri_spwm_gen #(.CAR_W(CW), .PH_W(PW), .DEAD_CYC(DT)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .freq_word (fw),
    .amp       (amp),
    .gate_hi   (ghi),
    .gate_lo   (glo)
  );

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 0;
  string tag     = "R10";

  // reference model state
  int            mcnt = 0;
  bit            mup  = 1;
  logic [PW-1:0] mph  = '0;
  int            mcmp [3] = '{MIDC, MIDC, MIDC};
  bit            mcur [3] = '{0, 0, 0};
  int            mtmr [3] = '{0, 0, 0};
  bit            mseen = 0;
  bit            men   = 0;

  function automatic int ref_sine(int n);
    int k = n % 128;
    int q = k * (128 - k);
    int v = (16 * 127 * q) / (5 * 16384 - 4 * q);
    return (n >= 128) ? -v : v;
  endfunction

  function automatic int ref_cmp(logic [PW-1:0] p, int a);
    int prod = ref_sine(int'(p[PW-1 -: 8])) * a;
    int sc;
    if (prod >= 0) sc = prod / DIVC;
    else           sc = -((-prod + DIVC - 1) / DIVC);
    return MIDC + sc;
  endfunction

  function automatic logic [PW-1:0] leg_ofs(int i);
    if (i == 0) return '0;
    if (i == 1) return PW'(5592405);
    return PW'(11184810);
  endfunction

  task automatic model_step();
    for (int i = 0; i < 3; i++) begin
      bit r = (mcmp[i] < mcnt);
      if (r != mcur[i]) begin
        mcur[i] = r;
        mtmr[i] = DT;
      end else if (mtmr[i] > 0) begin
        mtmr[i] = mtmr[i] - 1;
      end
    end
    if (mcnt == 0) begin
      for (int i = 0; i < 3; i++) mcmp[i] = ref_cmp(mph + leg_ofs(i), int'(amp));
      mph = mph + fw;
      if (mseen) men = 1;
    end
    if (mcnt == MAXC) mseen = 1;
    if (mup) begin
      mcnt = mcnt + 1;
      if (mcnt == MAXC) mup = 0;
    end else begin
      mcnt = mcnt - 1;
      if (mcnt == 0) mup = 1;
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [2:0] ehi;
    logic [2:0] elo;
    @(negedge clk);
    if (!rst) model_step();
    for (int i = 0; i < 3; i++) begin
      ehi[i] = men & mcur[i] & (mtmr[i] == 0);
      elo[i] = men & ~mcur[i] & (mtmr[i] == 0);
    end
    check({ghi, glo} == {ehi, elo}, tag, "gates {hi,lo}", int'({ghi, glo}), int'({ehi, elo}));
    // R9: no leg has both switches on
    check((ghi & glo) == 3'b000, "R9", "overlap", int'(ghi & glo), 0);
  endtask

  initial begin
    int nh;
    int nl;
    int n;
    bit prev;

    // R10: reset and startup hold
    tag = "R10";
    repeat (4) tick();
    rst = 1'b0;
    repeat (PERIOD + 10) tick();

    // R6: zero amplitude duty
    tag = "R6";
    repeat (2 * PERIOD) tick();
    nh = 0;
    nl = 0;
    repeat (PERIOD) begin
      tick();
      nh += int'(ghi[0]);
      nl += int'(glo[0]);
    end
    check(nh == 2 * (MAXC - MIDC) - 1 - DT, "R6", "upper on-cycles", nh, 2 * (MAXC - MIDC) - 1 - DT);
    check(nl == PERIOD - (2 * (MAXC - MIDC) - 1) - DT, "R6", "lower on-cycles", nl,
          PERIOD - (2 * (MAXC - MIDC) - 1) - DT);

    // R1: carrier period seen as the spacing of upper-switch turn-ons
    tag  = "R1";
    prev = ghi[0];
    n    = 0;
    while (!(prev == 1'b0 && ghi[0] == 1'b1) && n < 100) begin
      prev = ghi[0];
      tick();
      n++;
    end
    n = 0;
    prev = ghi[0];
    do begin
      prev = ghi[0];
      tick();
      n++;
    end while (!(prev == 1'b0 && ghi[0] == 1'b1) && n < 100);
    check(n == PERIOD, "R1", "turn-on spacing", n, PERIOD);

    // R8: blanking length between upper off and lower on
    tag  = "R8";
    n    = 0;
    prev = ghi[0];
    while (!(prev == 1'b1 && ghi[0] == 1'b0) && n < 100) begin
      prev = ghi[0];
      tick();
      n++;
    end
    n = 0;
    while (ghi[0] == 1'b0 && glo[0] == 1'b0 && n < 100) begin
      n++;
      tick();
    end
    check(n == DT, "R8", "blank cycles", n, DT);

    // R3: full table sweep at full scale
    tag = "R3";
    amp = 8'd255;
    fw  = PW'(24'h010000);
    repeat (256 * PERIOD) tick();

    // R4: odd tuning word, phase offsets between legs
    tag = "R4";
    amp = 8'd200;
    fw  = PW'(24'h0A3F11);
    repeat (60 * PERIOD) tick();

    // R2: comparison at a mid amplitude
    tag = "R2";
    amp = 8'd128;
    fw  = PW'(24'h020000);
    repeat (30 * PERIOD) tick();

    // R5: amplitude scaling over several depths
    tag = "R5";
    foreach (n_amps[j]) begin
      amp = n_amps[j];
      fw  = PW'(24'h031000);
      repeat (20 * PERIOD) tick();
    end

    // R7: inputs changed inside a carrier period
    tag = "R7";
    for (int p = 0; p < 60; p++) begin
      repeat (7) tick();
      amp = 8'((p * 53) % 256);
      repeat (11) tick();
      amp = 8'((p * 97 + 31) % 256);
      fw  = PW'((p * 24'h013579) & 24'hFFFFFF);
      repeat (11) tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  logic [7:0] n_amps [5] = '{8'd1, 8'd37, 8'd64, 8'd254, 8'd90};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule